// File: doc/BRIEF.md
# Dual-Compare Event Timer

This block is an 8-bit up-counter with two compare slots. Each slot holds a compare value and a 4-bit action mask. When the counter meets a slot's value on a counting step, the mask decides what that match does. It can clear the counter, invert a shared output flip-flop, or latch a sticky interrupt flag. It can also arm a one-shot mode that silences the slot after its first match.

The counter advances on a one-cycle tick pulse taken from one of four sources, chosen by a 2-bit select. The sources are the system clock, two pulses from neighbouring timers, and an external pin that is synchronised and rising-edge detected. Software loads every setting through a simple write port with a small address map. It also clears the interrupt flags through that port.

Top module: `dual_cmp_timer`

## Requirements
- R1: The counter is 8 bits wide and resets to 0. It rises by exactly one on each tick, wraps from 255 to 0, and holds its value when there is no tick.
- R2: Clock select 3 ticks every cycle and select 2 ticks on each cycle that `tmr_b_pulse` is high. Select 1 ticks on each cycle that `tmr_a_pulse` is high. Select 0 ticks once per rising edge of `ext_pin`, on the third clock edge after the pin rises. Sources that are not selected have no effect.
- R3: A slot matches on a cycle that has a tick and in which the counter value equals that slot's compare value. A match acts only through the enabled mask bits. With an all-zero mask, the counter keeps wrapping and the toggle and flags stay unchanged.
- R4: Mask bit 1 (counter clear) makes a match load 0 in place of the increment. A clear requested by either slot wins over the increment.
- R5: Mask bit 2 (toggle) makes a match invert `tog_o`. When both slots match in the same cycle and both request a toggle, `tog_o` inverts only once.
- R6: Mask bit 0 (interrupt) makes a match set that slot's sticky flag in `flag_o`. `irq_o` is the OR of the flags whose interrupt bit is set. A slot with bit 0 clear never sets its flag.
- R7: A write to address 5 clears each flag whose data bit (bit 0 for slot 1, bit 1 for slot 2) is 1. Flags whose data bit is 0 are left as they are.
- R8: Mask bit 3 (one-shot) lets a slot act on its first match only. Later matches of that slot are suppressed.
- R9: Writing a slot's compare value or its mask re-arms that slot's one-shot.
- R10: Address map: 0 is compare 1, 1 is compare 2, 2 is mask 1 (data[3:0]), 3 is mask 2, 4 is clock select (data[1:0]) and 5 is flag clear. Every register resets to 0, so after reset the block listens to `ext_pin` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| tmr_a_pulse | input | 1 | Tick pulse from the first neighbour timer |
| tmr_b_pulse | input | 1 | Tick pulse from the second neighbour timer |
| ext_pin | input | 1 | Asynchronous external count input |
| cnt_o | output | 8 | Current counter value |
| tog_o | output | 1 | Shared toggle flip-flop |
| irq_o | output | 1 | Timer interrupt |
| flag_o | output | 2 | Sticky per-slot interrupt flags |

## Verification
The table-driven part runs both slots with mask combinations against a tick-by-tick model of the requirements. It covers clear-versus-free-running periods, a compare value the counter never reaches because the other slot clears first, simultaneous toggles on equal compare values, and a one-shot with clear. Each pattern shows whether an action comes from the right slot and the right mask bit. Directed tests follow. They cover the one-shot staying silent across a full wrap and being re-armed by either kind of write, and selective flag clearing. They also cover each tick source counting while the others are driven and ignored, and the external pin counting once per pulse however long it stays high.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef struct packed {
        logic one_shot;
        logic toggle;
        logic clear;
        logic irq_en;
    } cmp_mode_t;

    localparam int MODE_W = $bits(cmp_mode_t);

    typedef enum logic [1:0] {
        SRC_EXT   = 2'b00,
        SRC_TMR_A = 2'b01,
        SRC_TMR_B = 2'b10,
        SRC_SYS   = 2'b11
    } tick_src_e;

    function automatic logic any_set(input logic [7:0] hits, input logic [7:0] mask);
        return |(hits & mask);
    endfunction

endpackage

// File: rtl/dct_tick_gen.sv
module dct_tick_gen
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  tick_src_e sel,
    input  logic      src_a,
    input  logic      src_b,
    input  logic      ext_pin,
    output logic      tick
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] ext_sh;
    logic            ext_rise;

    always_ff @(posedge clk) begin
        if (rst) ext_sh <= '0;
        else     ext_sh <= {ext_sh[SH_W-2:0], ext_pin};
    end

    assign ext_rise = ext_sh[SH_W-2] & ~ext_sh[SH_W-1];

    always_comb begin
        unique case (sel)
            SRC_SYS:   tick = 1'b1;
            SRC_TMR_B: tick = src_b;
            SRC_TMR_A: tick = src_a;
            default:   tick = ext_rise;
        endcase
    end

endmodule

// File: rtl/dct_cmp_slot.sv
module dct_cmp_slot
    import dct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  cmp_mode_t        mode,
    input  logic             rearm,
    output logic             hit
);
    logic armed;

    assign hit = tick && (cnt == cmp_val) && (!mode.one_shot || armed);

    always_ff @(posedge clk) begin
        if (rst)                       armed <= 1'b1;
        else if (rearm)                armed <= 1'b1;
        else if (hit && mode.one_shot) armed <= 1'b0;
    end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NUM_CMP = 2,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               tmr_a_pulse,
    input  logic               tmr_b_pulse,
    input  logic               ext_pin,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               tog_o,
    output logic               irq_o,
    output logic [NUM_CMP-1:0] flag_o
);
    localparam int MODE_BASE = NUM_CMP;
    localparam int SEL_ADDR  = 2 * NUM_CMP;
    localparam int CLR_ADDR  = 2 * NUM_CMP + 1;

    logic [CNT_W-1:0]   cmp_q  [NUM_CMP];
    cmp_mode_t          mode_q [NUM_CMP];
    tick_src_e          sel_q;
    logic [NUM_CMP-1:0] flag_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               tog_q;
    logic               tick;

    logic [NUM_CMP-1:0] hit, rearm, te_vec, re_vec, ie_vec, se_vec, clr_mask;
    logic [7:0]         hit8, te8, re8;

    dct_tick_gen #(.SYNC_STAGES(2)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_q),
        .src_a   (tmr_a_pulse),
        .src_b   (tmr_b_pulse),
        .ext_pin (ext_pin),
        .tick    (tick)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
        logic wr_cmp, wr_mode;
        assign wr_cmp   = wr_en && (wr_addr == ADDR_W'(i));
        assign wr_mode  = wr_en && (wr_addr == ADDR_W'(MODE_BASE + i));
        assign rearm[i] = wr_cmp || wr_mode;

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[i]  <= '0;
                mode_q[i] <= '0;
            end else begin
                if (wr_cmp)  cmp_q[i]  <= wr_data;
                if (wr_mode) mode_q[i] <= cmp_mode_t'(wr_data[MODE_W-1:0]);
            end
        end

        assign te_vec[i] = mode_q[i].toggle;
        assign re_vec[i] = mode_q[i].clear;
        assign ie_vec[i] = mode_q[i].irq_en;
        assign se_vec[i] = mode_q[i].one_shot;

        dct_cmp_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cnt     (cnt_q),
            .cmp_val (cmp_q[i]),
            .mode    (mode_q[i]),
            .rearm   (rearm[i]),
            .hit     (hit[i])
        );
    end

    assign hit8 = 8'(hit);
    assign te8  = 8'(te_vec);
    assign re8  = 8'(re_vec);

    always_ff @(posedge clk) begin
        if (rst)                             sel_q <= SRC_EXT;
        else if (wr_en && wr_addr == ADDR_W'(SEL_ADDR)) sel_q <= tick_src_e'(wr_data[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (any_set(hit8, re8)) cnt_q <= '0;
        else if (tick)             cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= tog_q ^ any_set(hit8, te8);
    end

    assign clr_mask = (wr_en && wr_addr == ADDR_W'(CLR_ADDR)) ? wr_data[NUM_CMP-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr_mask) | (hit & ie_vec);
    end

    assign cnt_o  = cnt_q;
    assign tog_o  = tog_q;
    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & ie_vec);

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int CNT_W   = 8,
    parameter int NUM_CMP = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [CNT_W-1:0]   cnt_o,
    input logic               tog_o,
    input logic               irq_o,
    input logic [NUM_CMP-1:0] flag_o,
    input logic [NUM_CMP-1:0] hit,
    input logic [NUM_CMP-1:0] te_vec,
    input logic [NUM_CMP-1:0] re_vec,
    input logic [NUM_CMP-1:0] se_vec
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cnt_o != $past(cnt_o)) |->
            (cnt_o == CNT_W'($past(cnt_o) + 1'b1) || cnt_o == '0)); // R1

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(|(hit & re_vec))) |-> (cnt_o == '0)); // R4

    AST_TOG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && tog_o != $past(tog_o)) |-> $past(|(hit & te_vec))); // R5

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|flag_o)); // R6

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_once
        AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && se_vec[i] && !wr_en) |=> !hit[i]); // R8
    end

endmodule

bind dual_cmp_timer dct_checker #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .cnt_o  (cnt_o),
    .tog_o  (tog_o),
    .irq_o  (irq_o),
    .flag_o (flag_o),
    .hit    (hit),
    .te_vec (te_vec),
    .re_vec (re_vec),
    .se_vec (se_vec)
);

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tmr_a_pulse = 1'b0;
    logic       tmr_b_pulse = 1'b0;
    logic       ext_pin = 1'b0;
    logic [7:0] cnt_o;
    logic       tog_o;
    logic       irq_o;
    logic [1:0] flag_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_cmp_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tmr_a_pulse(tmr_a_pulse), .tmr_b_pulse(tmr_b_pulse), .ext_pin(ext_pin),
        .cnt_o(cnt_o), .tog_o(tog_o), .irq_o(irq_o), .flag_o(flag_o)
    );

    // {cmp1, mask1, cmp2, mask2, ticks}
    localparam logic [39:0] VEC [8] = '{
        {8'd9,   4'h3, 8'd0,  4'h0, 16'd25},   // R4 R6: clear + irq on slot 1
        {8'd4,   4'h6, 8'd0,  4'h0, 16'd17},   // R4 R5: period 5, three toggles
        {8'd200, 4'h4, 8'd0,  4'h0, 16'd300},  // R1 R5: free run through wrap
        {8'd7,   4'hE, 8'd0,  4'h0, 16'd30},   // R8: one-shot with clear
        {8'd5,   4'h4, 8'd5,  4'h4, 16'd6},    // R5: simultaneous toggle
        {8'd3,   4'h2, 8'd10, 4'h1, 16'd40},   // R3 R6: slot 2 never reached
        {8'd10,  4'h1, 8'd4,  4'h6, 16'd50},   // R4 R5: slot 2 clears, slot 1 silent
        {8'd0,   4'h0, 8'd0,  4'h0, 16'd300}   // R3: zero masks, wrap
    };

    function automatic void model(input logic [7:0] c1, input logic [3:0] m1,
                                  input logic [7:0] c2, input logic [3:0] m2,
                                  input int n, output logic [7:0] cnt,
                                  output logic tg, output logic [1:0] fl);
        logic a1, a2, h1, h2;
        cnt = 0; tg = 0; fl = 0; a1 = 1; a2 = 1;
        for (int t = 0; t < n; t++) begin
            h1 = (cnt == c1) && (!m1[3] || a1);
            h2 = (cnt == c2) && (!m2[3] || a2);
            if (h1 && m1[3]) a1 = 0;
            if (h2 && m2[3]) a2 = 0;
            tg = tg ^ ((h1 && m1[2]) || (h2 && m2[2]));
            fl[0] = fl[0] | (h1 && m1[0]);
            fl[1] = fl[1] | (h2 && m2[0]);
            cnt = ((h1 && m1[1]) || (h2 && m2[1])) ? 8'd0 : cnt + 8'd1;
        end
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        wr(3'd4, 8'd3);
        repeat (n - 1) @(negedge clk);
        wr(3'd4, 8'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [7:0] e_cnt;
        logic       e_tg;
        logic [1:0] e_fl;

        do_reset();
        check("R10 reset cnt", cnt_o, 0);
        check("R10 reset tog", tog_o, 0);
        check("R10 reset irq", irq_o, 0);
        check("R10 reset flags", flag_o, 0);

        // R10: default select is the external pin; neighbour pulses ignored
        tmr_a_pulse = 1'b1; tmr_b_pulse = 1'b1;
        repeat (4) @(negedge clk);
        tmr_a_pulse = 1'b0; tmr_b_pulse = 1'b0;
        check("R10 default select ignores timers", cnt_o, 0);

        for (int v = 0; v < 8; v++) begin
            do_reset();
            wr(3'd0, VEC[v][39:32]);
            wr(3'd2, {4'h0, VEC[v][31:28]});
            wr(3'd1, VEC[v][27:20]);
            wr(3'd3, {4'h0, VEC[v][19:16]});
            run(int'(VEC[v][15:0]));
            model(VEC[v][39:32], VEC[v][31:28], VEC[v][27:20], VEC[v][19:16],
                  int'(VEC[v][15:0]), e_cnt, e_tg, e_fl);
            check($sformatf("R1 R3 R4 vec%0d cnt", v), cnt_o, e_cnt);
            check($sformatf("R5 R8 vec%0d tog", v), tog_o, e_tg);
            check($sformatf("R6 vec%0d flags", v), flag_o, e_fl);
            check($sformatf("R6 vec%0d irq", v), irq_o, int'(|e_fl));
        end

        // R8 / R9: one-shot suppression and re-arm
        do_reset();
        wr(3'd0, 8'd7);
        wr(3'd2, 8'h0E);
        run(30);
        check("R8 first hit cnt", cnt_o, 22);
        check("R8 first hit tog", tog_o, 1);
        run(300);
        check("R8 suppressed across wrap cnt", cnt_o, 66);
        check("R8 suppressed across wrap tog", tog_o, 1);
        wr(3'd2, 8'h0E);
        run(200);
        check("R9 rearm by mask cnt", cnt_o, 2);
        check("R9 rearm by mask tog", tog_o, 0);
        wr(3'd0, 8'd7);
        run(10);
        check("R9 rearm by compare cnt", cnt_o, 4);
        check("R9 rearm by compare tog", tog_o, 1);

        // R7: selective flag clear
        do_reset();
        wr(3'd0, 8'd3);
        wr(3'd2, 8'h03);
        run(5);
        check("R6 flag set", flag_o, 1);
        check("R6 irq set", irq_o, 1);
        wr(3'd5, 8'h00);
        check("R7 zero write keeps flag", flag_o, 1);
        wr(3'd5, 8'h02);
        check("R7 other bit keeps flag", flag_o, 1);
        wr(3'd5, 8'h01);
        check("R7 flag cleared", flag_o, 0);
        check("R7 irq cleared", irq_o, 0);

        // R2: neighbour timer sources
        do_reset();
        wr(3'd4, 8'd1);
        tmr_b_pulse = 1'b1;
        tmr_a_pulse = 1'b1;
        repeat (5) @(negedge clk);
        tmr_a_pulse = 1'b0;
        repeat (2) @(negedge clk);
        tmr_b_pulse = 1'b0;
        check("R2 select 1 counts timer A only", cnt_o, 5);
        wr(3'd4, 8'd2);
        tmr_a_pulse = 1'b1;
        tmr_b_pulse = 1'b1;
        repeat (3) @(negedge clk);
        tmr_b_pulse = 1'b0;
        repeat (2) @(negedge clk);
        tmr_a_pulse = 1'b0;
        check("R2 select 2 counts timer B only", cnt_o, 8);

        // R2: external pin, one count per rising edge
        do_reset();
        for (int p = 0; p < 3; p++) begin
            ext_pin = 1'b1;
            repeat (4) @(negedge clk);
            ext_pin = 1'b0;
            repeat (4) @(negedge clk);
        end
        check("R2 external pulses", cnt_o, 3);
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 external latency before third edge", cnt_o, 3);
        @(negedge clk);
        check("R2 external count on third edge", cnt_o, 4);
        ext_pin = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule